// File: doc/BRIEF.md
# OTP fuse word read sequencer

This block turns a single host request into the timed handshake needed to read one 32-bit word out of a one-time-programmable fuse array. The host gives a request kind, a bank index and a word index, then pulses a one-cycle start strobe. The block validates the request, waits for the array to go idle, pulses a clear of the array's sticky error flag, then raises the bank-open control. It waits a fixed blind settle interval before it looks at the array's busy line at all, because busy can rise several clocks after the banks open. It polls busy with a bounded retry budget and adds a postamble wait once busy is low. It then captures the selected word and lowers bank-open again.

The response is a one-cycle done pulse with a 32-bit data word and a two-bit error code. Only plain reads are served. Sense and override requests, and the reserved kind, are refused at once with an invalid-argument code, and the array is not touched. While a request is in progress, further start strobes are ignored.

Top module: `otp_read_seq`

## Requirements
- R1: While rst_n is low and on the first cycle after its release, rsp_done, arr_bank_open and arr_err_clr are all 0.
- R2: A read whose bank index is greater than 4 or whose word index is greater than 7 completes with rsp_err = 2'b01 (invalid argument) and rsp_data = 0. rsp_done is visible in the cycle after the strobe is sampled, and arr_bank_open never rises.
- R3: A request with req_kind 2'b01 (sense), 2'b10 (override) or 2'b11 (reserved) completes like R2 with rsp_err = 2'b01. Only req_kind 2'b00 performs a read.
- R4: During an accepted read, arr_addr equals BASE_OFF + (((bank << 3) | word) << 4), with a default BASE_OFF of 0x400. It holds steady for the whole time arr_bank_open is high.
- R5: Before touching the array, the block waits for arr_busy to be low. If busy stays high for POLL_MAX cycles, the read ends with rsp_err = 2'b10 (timeout) and rsp_data = 0, without any error clear and without bank-open.
- R6: Each accepted read gives exactly one single-cycle arr_err_clr pulse. arr_bank_open rises in the cycle right after that pulse.
- R7: arr_busy is not sampled during the first SETTLE_CYC cycles of arr_bank_open, so a busy that rises late inside that window still holds off the capture until it falls.
- R8: If arr_busy stays high for POLL_MAX polls after the settle window, arr_bank_open falls after SETTLE_CYC + POLL_MAX cycles. The read then ends with rsp_err = 2'b10 and rsp_data = 0.
- R9: When busy is low after the settle window, arr_bank_open stays high for exactly SETTLE_CYC + 1 + POST_CYC + 1 cycles. rsp_data returns the arr_rdata value present in the last of those cycles, with rsp_err = 2'b00.
- R10: arr_bank_open is low whenever rsp_done is high.
- R11: rsp_done is high for exactly one cycle per request. A start strobe that arrives before that pulse has ended is ignored, giving no extra done and no change of arr_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle request strobe |
| req_kind | input | 2 | 00 read, 01 sense, 10 override, 11 reserved |
| req_bank | input | 4 | Bank index |
| req_word | input | 4 | Word index within the bank |
| arr_busy | input | 1 | Fuse array busy indication |
| arr_rdata | input | 32 | Word presented by the array at arr_addr |
| arr_bank_open | output | 1 | Opens the read banks while high |
| arr_err_clr | output | 1 | One-cycle clear of the array's sticky error flag |
| arr_addr | output | 12 | Byte address of the selected word |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_data | output | 32 | Captured word, zero on error |
| rsp_err | output | 2 | 00 ok, 01 invalid argument, 10 timeout |

## Verification
A sequencer stuck in or skipping a state shows up at the ports within one request. A skipped settle or postamble count changes the bank-open window length, which is measured cycle by cycle. An early poll captures the junk word that the bench drives while busy is high. A lost error clear or wrong ordering shows up as a bank-open edge without the pulse right before it. A wrong timer load shifts the timeout window by a countable number of cycles. A broken idle guard shows up as a second done pulse or an address change during the open window.

// File: rtl/otp_read_pkg.sv
// Shared encodings for the OTP read sequencer.
// Assumes: two-bit request kind and error codes as stated in the brief.
package otp_read_pkg;

    typedef enum logic [1:0] {
        KIND_READ     = 2'b00,
        KIND_SENSE    = 2'b01,
        KIND_OVERRIDE = 2'b10,
        KIND_RSVD     = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        RERR_NONE    = 2'b00,
        RERR_INVAL   = 2'b01,
        RERR_TIMEOUT = 2'b10
    } rsp_err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT_IDLE,
        ST_CLR_ERR,
        ST_SETTLE,
        ST_POLL,
        ST_POST,
        ST_CAPTURE,
        ST_CLOSE,
        ST_DONE
    } seq_state_e;

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/otp_req_check.sv
// Request validation and word address formation.
// Purely combinational. Assumes WORD_MAX + 1 is a power of two so that the
// word number is {bank, word}; the address is valid only when ok is high.
module otp_req_check #(
    parameter int unsigned BANK_W    = 4,
    parameter int unsigned WORD_W    = 4,
    parameter int unsigned BANK_MAX  = 4,
    parameter int unsigned WORD_MAX  = 7,
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned BASE_OFF  = 'h400,
    parameter int unsigned STRIDE_SH = 4
) (
    input  logic [1:0]        kind,
    input  logic [BANK_W-1:0] bank,
    input  logic [WORD_W-1:0] word,
    output logic              ok,
    output logic [ADDR_W-1:0] addr
);
    import otp_read_pkg::*;

    localparam int unsigned BSEL_W = $clog2(BANK_MAX + 1);
    localparam int unsigned WSEL_W = $clog2(WORD_MAX + 1);
    localparam int unsigned WNUM_W = BSEL_W + WSEL_W;
    localparam logic [BANK_W-1:0] BANK_LIM = BANK_W'(BANK_MAX);
    localparam logic [WORD_W-1:0] WORD_LIM = WORD_W'(WORD_MAX);
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_OFF);

    logic [WNUM_W-1:0] word_num;

    // Accept only reads with both indices inside the array.
    always_comb begin
        ok = (kind == KIND_READ) && (bank <= BANK_LIM) && (word <= WORD_LIM);
    end

    // Linear word number, then base plus 16-byte stride.
    always_comb begin
        word_num = {bank[BSEL_W-1:0], word[WSEL_W-1:0]};
        addr     = BASE_A + ADDR_W'({word_num, {STRIDE_SH{1'b0}}});
    end

endmodule

// File: rtl/otp_cycle_timer.sv
// Down counter shared by the settle, poll and postamble windows.
// A load sets the count; it then decrements to zero and stays there.
// zero is high in the cycle the count reads zero.
module otp_cycle_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    // Load or count down, saturating at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Expiry flag.
    always_comb begin
        zero = (cnt_q == '0);
    end

endmodule

// File: rtl/otp_read_fsm.sv
// Control sequence for one fuse word read.
// Assumes SETTLE_CYC, POST_CYC and POLL_MAX are all at least 1, and that the
// timer it drives reports expiry in the cycle its count reaches zero.
module otp_read_fsm #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CNT_W      = 8,
    parameter int unsigned SETTLE_CYC = 8,
    parameter int unsigned POST_CYC   = 8,
    parameter int unsigned POLL_MAX   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              req_ok,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              busy,
    input  logic [DATA_W-1:0] rdata,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [CNT_W-1:0]  tmr_val,
    output logic              bank_open,
    output logic              err_clr,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic [1:0]        err
);
    import otp_read_pkg::*;

    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] POST_LD   = CNT_W'(POST_CYC - 1);
    localparam logic [CNT_W-1:0] POLL_LD   = CNT_W'(POLL_MAX - 1);

    seq_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    rsp_err_e          err_q;

    // Next state and timer loads.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (req_ok) begin
                        state_d  = ST_WAIT_IDLE;
                        tmr_load = 1'b1;
                        tmr_val  = POLL_LD;
                    end else begin
                        state_d = ST_DONE;
                    end
                end
            end
            ST_WAIT_IDLE: begin
                if (!busy)         state_d = ST_CLR_ERR;
                else if (tmr_zero) state_d = ST_DONE;
            end
            ST_CLR_ERR: begin
                state_d  = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = SETTLE_LD;
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    state_d  = ST_POLL;
                    tmr_load = 1'b1;
                    tmr_val  = POLL_LD;
                end
            end
            ST_POLL: begin
                if (!busy) begin
                    state_d  = ST_POST;
                    tmr_load = 1'b1;
                    tmr_val  = POST_LD;
                end else if (tmr_zero) begin
                    state_d = ST_CLOSE;
                end
            end
            ST_POST: begin
                if (tmr_zero) state_d = ST_CAPTURE;
            end
            ST_CAPTURE: state_d = ST_CLOSE;
            ST_CLOSE:   state_d = ST_DONE;
            ST_DONE:    state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request address, result data and error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            err_q  <= RERR_NONE;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= req_addr;
                        data_q <= '0;
                        err_q  <= req_ok ? RERR_NONE : RERR_INVAL;
                    end
                end
                ST_WAIT_IDLE: begin
                    if (busy && tmr_zero) err_q <= RERR_TIMEOUT;
                end
                ST_POLL: begin
                    if (busy && tmr_zero) err_q <= RERR_TIMEOUT;
                end
                ST_CAPTURE: data_q <= rdata;
                default: ;
            endcase
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        bank_open = (state_q == ST_SETTLE) || (state_q == ST_POLL) ||
                    (state_q == ST_POST)   || (state_q == ST_CAPTURE);
        err_clr   = (state_q == ST_CLR_ERR);
        done      = (state_q == ST_DONE);
        addr      = addr_q;
        data      = data_q;
        err       = err_q;
    end

endmodule

// File: rtl/otp_read_seq.sv
// Top of the OTP fuse word read sequencer.
// Validates a host request, then runs clear, open, settle, poll, postamble,
// capture and close against the array, and returns data with a done pulse.
// Assumes arr_rdata is valid for arr_addr while the banks are open.
module otp_read_seq #(
    parameter int unsigned CLK_HZ     = 24_000_000,
    parameter int unsigned SETTLE_CYC = CLK_HZ / 100_000,
    parameter int unsigned POST_CYC   = CLK_HZ / 100_000,
    parameter int unsigned POLL_MAX   = 1000,
    parameter int unsigned BANK_W     = 4,
    parameter int unsigned WORD_W     = 4,
    parameter int unsigned BANK_MAX   = 4,
    parameter int unsigned WORD_MAX   = 7,
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned BASE_OFF   = 'h400,
    parameter int unsigned STRIDE_SH  = 4,
    parameter int unsigned DATA_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic [1:0]        req_kind,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [WORD_W-1:0] req_word,
    input  logic              arr_busy,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              arr_bank_open,
    output logic              arr_err_clr,
    output logic [ADDR_W-1:0] arr_addr,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_err
);
    import otp_read_pkg::*;

    localparam int unsigned TMAX  = max3(SETTLE_CYC, POST_CYC, POLL_MAX);
    localparam int unsigned CNT_W = $clog2(TMAX + 1);

    logic              req_ok;
    logic [ADDR_W-1:0] req_addr;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;

    otp_req_check #(
        .BANK_W   (BANK_W),
        .WORD_W   (WORD_W),
        .BANK_MAX (BANK_MAX),
        .WORD_MAX (WORD_MAX),
        .ADDR_W   (ADDR_W),
        .BASE_OFF (BASE_OFF),
        .STRIDE_SH(STRIDE_SH)
    ) u_check (
        .kind(req_kind),
        .bank(req_bank),
        .word(req_word),
        .ok  (req_ok),
        .addr(req_addr)
    );

    otp_cycle_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    otp_read_fsm #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .SETTLE_CYC(SETTLE_CYC),
        .POST_CYC  (POST_CYC),
        .POLL_MAX  (POLL_MAX)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_start),
        .req_ok   (req_ok),
        .req_addr (req_addr),
        .busy     (arr_busy),
        .rdata    (arr_rdata),
        .tmr_zero (tmr_zero),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .bank_open(arr_bank_open),
        .err_clr  (arr_err_clr),
        .addr     (arr_addr),
        .done     (rsp_done),
        .data     (rsp_data),
        .err      (rsp_err)
    );

endmodule

// File: rtl/otp_read_seq_chk.sv
// Property checker for otp_read_seq, attached with bind below.
// Assumes synchronous active-low reset; all properties are disabled in reset.
module otp_read_seq_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              arr_bank_open,
    input logic              arr_err_clr,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              rsp_done,
    input logic [DATA_W-1:0] rsp_data,
    input logic [1:0]        rsp_err
);

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10
    closed_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !arr_bank_open);

    // R6
    clr_then_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_err_clr |=> arr_bank_open);

    // R6
    open_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_bank_open) |-> $past(arr_err_clr));

    // R4
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_bank_open && $past(arr_bank_open)) |-> $stable(arr_addr));

    // R2
    err_data_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err != 2'b00) |-> rsp_data == '0);

endmodule

bind otp_read_seq otp_read_seq_chk #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .arr_bank_open(arr_bank_open),
    .arr_err_clr  (arr_err_clr),
    .arr_addr     (arr_addr),
    .rsp_done     (rsp_done),
    .rsp_data     (rsp_data),
    .rsp_err      (rsp_err)
);

// File: tb/otp_read_seq_tb.sv
// Directed bench for otp_read_seq: one task per scenario.
module otp_read_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int SETTLE = 8;
    localparam int POST   = 5;
    localparam int POLLN  = 20;
    localparam int BASE   = 'h400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [3:0]  req_bank = '0;
    logic [3:0]  req_word = '0;
    logic        arr_busy = 1'b0;
    logic [31:0] arr_rdata = '0;
    logic        arr_bank_open, arr_err_clr, rsp_done;
    logic [11:0] arr_addr;
    logic [31:0] rsp_data;
    logic [1:0]  rsp_err;

    int n_vec = 0;
    int n_bad = 0;

    int done_cnt = 0, dbl_done = 0, clr_cnt = 0, clr_bad = 0, open_cnt = 0;
    int close_bad = 0, cur_len = 0, last_len = 0, addr_bad = 0;
    logic [11:0] open_addr = '0;
    logic prev_done = 0, prev_clr = 0, prev_open = 0;

    otp_read_seq #(
        .SETTLE_CYC(SETTLE),
        .POST_CYC  (POST),
        .POLL_MAX  (POLLN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_kind(req_kind),
        .req_bank(req_bank), .req_word(req_word), .arr_busy(arr_busy),
        .arr_rdata(arr_rdata), .arr_bank_open(arr_bank_open),
        .arr_err_clr(arr_err_clr), .arr_addr(arr_addr), .rsp_done(rsp_done),
        .rsp_data(rsp_data), .rsp_err(rsp_err)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Port monitor, sampled on the falling edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_done <= 0; prev_clr <= 0; prev_open <= 0;
        end else begin
            if (rsp_done) done_cnt++;
            if (rsp_done && prev_done) dbl_done++;
            if (arr_err_clr) begin clr_cnt++; if (arr_bank_open) clr_bad++; end
            if (prev_clr && !arr_bank_open) clr_bad++;
            if (arr_bank_open && !prev_open) begin
                open_cnt++; cur_len = 0; open_addr = arr_addr;
            end
            if (arr_bank_open) begin
                cur_len++;
                if (arr_addr != open_addr) addr_bad++;
            end else if (prev_open) last_len = cur_len;
            if (rsp_done && arr_bank_open) close_bad++;
            prev_done <= rsp_done; prev_clr <= arr_err_clr; prev_open <= arr_bank_open;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic strobe(input logic [1:0] k, input logic [3:0] b, input logic [3:0] w);
        @(negedge clk);
        req_kind = k; req_bank = b; req_word = w; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done(output logic [1:0] e, output logic [31:0] d, output int lat);
        lat = 0;
        while (!rsp_done && lat < 400) begin @(negedge clk); lat++; end
        e = rsp_err; d = rsp_data;
        if (!rsp_done) chk(0, "done_seen", 0, 1);
    endtask

    task automatic wait_open();
        int i = 0;
        while (!arr_bank_open && i < 100) begin @(negedge clk); i++; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!rsp_done, "R1 done in reset", rsp_done, 0);
        chk(!arr_bank_open, "R1 open in reset", arr_bank_open, 0);
        chk(!arr_err_clr, "R1 clr in reset", arr_err_clr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_done && !arr_bank_open && !arr_err_clr, "R1 after release",
            {rsp_done, arr_bank_open, arr_err_clr}, 0);
    endtask

    task automatic t_reject(input logic [1:0] k, input logic [3:0] b, input logic [3:0] w,
                            input string tag);
        logic [1:0] e; logic [31:0] d; int lat; int o0 = open_cnt; int c0 = clr_cnt;
        strobe(k, b, w);
        wait_done(e, d, lat);
        chk(lat == 0, {tag, " latency"}, lat, 0);
        chk(e == 2'b01, {tag, " err"}, e, 1);
        chk(d == 0, {tag, " data"}, d, 0);
        chk(open_cnt == o0 && clr_cnt == c0, {tag, " array untouched"}, open_cnt - o0, 0);
    endtask

    task automatic t_read(input logic [3:0] b, input logic [3:0] w, input logic [31:0] val);
        logic [1:0] e; logic [31:0] d; int lat; int c0 = clr_cnt; int bad0 = clr_bad;
        int exp_addr = BASE + ((b * 8 + w) * 16);
        arr_rdata = val;
        strobe(2'b00, b, w);
        wait_done(e, d, lat);
        chk(e == 2'b00, "R9 read err", e, 0);
        chk(d == val, "R9 read data", d, val);
        chk(last_len == SETTLE + 1 + POST + 1, "R9 open window", last_len, SETTLE + POST + 2);
        chk(open_addr == exp_addr[11:0], "R4 address", open_addr, exp_addr);
        chk(clr_cnt == c0 + 1 && clr_bad == bad0, "R6 clear once before open", clr_cnt - c0, 1);
        chk(close_bad == 0, "R10 closed at done", close_bad, 0);
        @(negedge clk);
        chk(!rsp_done && dbl_done == 0, "R11 done one cycle", dbl_done, 0);
    endtask

    task automatic t_late_busy();
        logic [1:0] e; logic [31:0] d; int lat;
        arr_rdata = 32'hDEAD_0000;
        strobe(2'b00, 4'd1, 4'd2);
        wait_open();
        repeat (2) @(negedge clk);
        arr_busy = 1'b1; arr_rdata = 32'hBAD0_BAD0;
        repeat (12) @(negedge clk);
        arr_busy = 1'b0; arr_rdata = 32'h1234_5678;
        wait_done(e, d, lat);
        chk(d == 32'h1234_5678, "R7 late busy honoured", d, 32'h1234_5678);
        chk(e == 2'b00, "R7 err", e, 0);
    endtask

    task automatic t_poll_timeout();
        logic [1:0] e; logic [31:0] d; int lat;
        arr_rdata = 32'hCAFE_F00D;
        strobe(2'b00, 4'd3, 4'd5);
        wait_open();
        arr_busy = 1'b1;
        wait_done(e, d, lat);
        arr_busy = 1'b0;
        chk(e == 2'b10, "R8 timeout err", e, 2);
        chk(d == 0, "R8 timeout data", d, 0);
        chk(last_len == SETTLE + POLLN, "R8 open window", last_len, SETTLE + POLLN);
    endtask

    task automatic t_idle_timeout();
        logic [1:0] e; logic [31:0] d; int lat; int o0 = open_cnt; int c0 = clr_cnt;
        arr_busy = 1'b1;
        strobe(2'b00, 4'd0, 4'd0);
        wait_done(e, d, lat);
        arr_busy = 1'b0;
        chk(e == 2'b10, "R5 idle timeout err", e, 2);
        chk(lat == POLLN, "R5 idle wait length", lat, POLLN);
        chk(open_cnt == o0 && clr_cnt == c0, "R5 no clear or open", clr_cnt - c0, 0);
    endtask

    task automatic t_ignore_start();
        logic [1:0] e; logic [31:0] d; int lat; int dn0;
        arr_rdata = 32'h0F0F_A5A5;
        strobe(2'b00, 4'd4, 4'd7);
        dn0 = done_cnt;
        wait_open();
        strobe(2'b00, 4'd0, 4'd1);
        wait_done(e, d, lat);
        repeat (SETTLE + POST + 10) @(negedge clk);
        chk(done_cnt == dn0 + 1, "R11 extra start ignored", done_cnt - dn0, 1);
        chk(open_addr == 12'h670 && addr_bad == 0, "R11 address kept", open_addr, 'h670);
        chk(d == 32'h0F0F_A5A5, "R11 data", d, 32'h0F0F_A5A5);
    endtask

    initial begin
        t_reset();
        t_reject(2'b00, 4'd5, 4'd0, "R2 bank 5");
        t_reject(2'b00, 4'd0, 4'd8, "R2 word 8");
        t_reject(2'b01, 4'd0, 4'd0, "R3 sense");
        t_reject(2'b10, 4'd1, 4'd1, "R3 override");
        t_reject(2'b11, 4'd2, 4'd2, "R3 reserved");
        t_read(4'd0, 4'd0, 32'hA5A5_0001);
        t_read(4'd4, 4'd7, 32'h5A5A_FFFE);
        t_read(4'd2, 4'd3, 32'h0000_8000);
        t_late_busy();
        t_poll_timeout();
        t_idle_timeout();
        t_ignore_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule